// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Multiplier

This block multiplies two IEEE 754 binary32 words over several clock cycles. Each operand and the result travel on their own strobe/acknowledge stream. The block raises the acknowledge of the first operand stream and waits for a strobe there. It then does the same on the second operand stream. After that it works through the product and holds the result on the output stream until the consumer acknowledges it.

Internally a state machine classifies both operands and settles the special cases at once. It brings subnormal mantissas to normal form one bit per cycle. It then forms the 48-bit mantissa product, scaled by four so that the guard and round bits land at fixed positions, and uses a matching exponent sum of `ea + eb + 1`. Finally it renormalises, shifts right into the subnormal range when needed, rounds to nearest with ties to even, and packs the result. Latency therefore depends on the data. Two subnormal operands make the block spend the most cycles in its shift states.

Top module: `fmul32_seq`

## Requirements
- R1: After reset `a_ack` is 1 and `b_ack` and `z_valid` are 0. A word on the `b` stream is not taken while `a` is outstanding. Once `a` is accepted (`a_valid` and `a_ack` high at a clock edge), `b_ack` rises on the next cycle and `a_ack` falls.
- R2: While `z_valid` is 1 and `z_ack` is 0, `z_valid` stays 1 and `z_data` does not change. A cycle with both high ends the transfer, and `a_ack` returns to 1.
- R3: Products of normal operands are rounded to nearest, with an exact halfway case going to the even mantissa (bit 0 of the 23-bit fraction field equal to 0).
- R4: Subnormal operands (exponent field 0, fraction nonzero) are multiplied with their true value. This holds when both operands are subnormal, and the block still returns a result.
- R5: Results below the normal range are delivered as correctly rounded subnormals. A result that rounds up to the smallest normal is encoded with exponent field 1.
- R6: A rounded magnitude of 2^128 or more gives an infinity (exponent field 0xFF, fraction 0). A magnitude that rounds below half the smallest subnormal gives a zero.
- R7: Infinity times zero, in either order, gives 0xFFC00000. Any NaN operand (exponent field 0xFF, fraction nonzero) also gives 0xFFC00000.
- R8: Every result other than 0xFFC00000 has bit 31 equal to the XOR of the operand sign bits. Infinity times a finite nonzero value is an infinity. Zero times a finite value is a zero.
- R9: `a_ack` and `b_ack` are never high together, and neither is high while `z_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_data | input | 32 | First operand word |
| a_valid | input | 1 | Strobe for the first operand |
| a_ack | output | 1 | Block is ready to take the first operand |
| b_data | input | 32 | Second operand word |
| b_valid | input | 1 | Strobe for the second operand |
| b_ack | output | 1 | Block is ready to take the second operand |
| z_data | output | 32 | Product word |
| z_valid | output | 1 | Product is available |
| z_ack | input | 1 | Consumer takes the product |

## Verification
The checker watches the handshake protocol on every cycle: the reset state, the hand-over from the first to the second operand, mutually exclusive acknowledges, and a stable held result. It also captures each accepted operand, so it can confirm the NaN result and the XOR sign of every delivered word. The numeric value of products can only be shown by the bench's scenarios. These cover ties to even, subnormal inputs and outputs, rounding across the subnormal/normal boundary, overflow and underflow, and a sweep of varied words compared against an integer reference model.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MANT_W = FRAC_W + 1;
  localparam int E_W    = EXP_W + 2;               // signed working exponent
  localparam int PROD_W = 2 * MANT_W + 2;          // product scaled by four

  localparam logic signed [E_W-1:0] E_MAX = E_W'((2 ** (EXP_W - 1)) - 1);
  localparam logic signed [E_W-1:0] E_MIN = E_W'(2 - (2 ** (EXP_W - 1)));
  localparam logic signed [E_W-1:0] E_ONE = E_W'(1);
  localparam logic [E_W-1:0]        E_BIAS = E_W'((2 ** (EXP_W - 1)) - 1);
  localparam logic [WORD_W-1:0]     QNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              sign;
    logic [E_W-1:0]    exp;
    logic [MANT_W-1:0] mant;
    logic              nan;
    logic              inf;
    logic              zero;
  } op_t;

  typedef enum logic [3:0] {
    S_GET_A, S_GET_B, S_UNPACK, S_NORM_A, S_NORM_B,
    S_MULT, S_NORM1, S_NORM2, S_ROUND, S_PUT_Z
  } st_t;
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
  import fmul_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output op_t               op
);
  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] ff;

  always_comb begin
    ef      = word[WORD_W-2 -: EXP_W];
    ff      = word[FRAC_W-1:0];
    op.sign = word[WORD_W-1];
    op.nan  = (&ef) && (|ff);
    op.inf  = (&ef) && !(|ff);
    op.zero = !(|ef) && !(|ff);
    if (!(|ef)) begin
      op.mant = {1'b0, ff};
      op.exp  = E_MIN;
    end else begin
      op.mant = {1'b1, ff};
      op.exp  = E_W'(ef) - E_BIAS;
    end
  end
endmodule

// File: rtl/fmul_pack.sv
module fmul_pack
  import fmul_pkg::*;
(
  input  logic                    sign,
  input  logic signed [E_W-1:0]   exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    guard,
  input  logic                    rnd,
  input  logic                    sticky,
  output logic [WORD_W-1:0]       word
);
  logic                  up;
  logic [MANT_W:0]       m_inc;
  logic [MANT_W-1:0]     m_r;
  logic signed [E_W-1:0] e_r;
  logic [E_W-1:0]        biased;
  logic [EXP_W-1:0]      field;

  always_comb begin
    up     = guard && (rnd || sticky || mant_i[0]);
    m_inc  = {1'b0, mant_i} + {{MANT_W{1'b0}}, up};
    e_r    = exp_i;
    m_r    = m_inc[MANT_W-1:0];
    if (m_inc[MANT_W]) begin
      e_r = exp_i + E_ONE;
      m_r = m_inc[MANT_W:1];
    end
    biased = e_r + E_BIAS;
    field  = (e_r == E_MIN && !m_r[MANT_W-1]) ? '0 : biased[EXP_W-1:0];
    if (e_r > E_MAX) word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else             word = {sign, field, m_r[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fmul32_seq.sv
module fmul32_seq
  import fmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] a_data,
  input  logic              a_valid,
  output logic              a_ack,
  input  logic [WORD_W-1:0] b_data,
  input  logic              b_valid,
  output logic              b_ack,
  output logic [WORD_W-1:0] z_data,
  output logic              z_valid,
  input  logic              z_ack
);
  st_t                   st;
  logic [WORD_W-1:0]     a_w, b_w;
  op_t                   op_u [2];
  op_t                   op_a, op_b;
  logic signed [E_W-1:0] ze;
  logic [MANT_W-1:0]     zm;
  logic                  g, rb, sb, zs;
  logic [2*MANT_W-1:0]   prod;
  logic [PROD_W-1:0]     prod4;
  logic [WORD_W-1:0]     packed_w;
  logic                  s_x;

  for (genvar i = 0; i < 2; i++) begin : g_unp
    fmul_unpack u_unp (.word(i == 0 ? a_w : b_w), .op(op_u[i]));
  end

  assign prod  = op_a.mant * op_b.mant;
  assign prod4 = {prod, 2'b00};
  assign s_x   = op_u[0].sign ^ op_u[1].sign;

  fmul_pack u_pack (
    .sign(zs), .exp_i(ze), .mant_i(zm), .guard(g), .rnd(rb), .sticky(sb), .word(packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_GET_A;
      a_ack   <= 1'b1;
      b_ack   <= 1'b0;
      z_valid <= 1'b0;
      z_data  <= '0;
      a_w     <= '0;
      b_w     <= '0;
      op_a    <= '0;
      op_b    <= '0;
      ze      <= '0;
      zm      <= '0;
      g       <= 1'b0;
      rb      <= 1'b0;
      sb      <= 1'b0;
      zs      <= 1'b0;
    end else begin
      case (st)
        S_GET_A: if (a_valid) begin
          a_w   <= a_data;
          a_ack <= 1'b0;
          b_ack <= 1'b1;
          st    <= S_GET_B;
        end
        S_GET_B: if (b_valid) begin
          b_w   <= b_data;
          b_ack <= 1'b0;
          st    <= S_UNPACK;
        end
        S_UNPACK: begin
          op_a <= op_u[0];
          op_b <= op_u[1];
          zs   <= s_x;
          st   <= S_NORM_A;
          if (op_u[0].nan || op_u[1].nan ||
              (op_u[0].inf && op_u[1].zero) || (op_u[1].inf && op_u[0].zero)) begin
            z_data <= QNAN;
            z_valid <= 1'b1;
            st <= S_PUT_Z;
          end else if (op_u[0].inf || op_u[1].inf) begin
            z_data <= {s_x, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            z_valid <= 1'b1;
            st <= S_PUT_Z;
          end else if (op_u[0].zero || op_u[1].zero) begin
            z_data <= {s_x, {(WORD_W-1){1'b0}}};
            z_valid <= 1'b1;
            st <= S_PUT_Z;
          end
        end
        S_NORM_A: begin
          if (op_a.mant[MANT_W-1]) st <= S_NORM_B;
          else begin
            op_a.mant <= op_a.mant << 1;
            op_a.exp  <= op_a.exp - E_ONE;
          end
        end
        S_NORM_B: begin
          if (op_b.mant[MANT_W-1]) st <= S_MULT;
          else begin
            op_b.mant <= op_b.mant << 1;
            op_b.exp  <= op_b.exp - E_ONE;
          end
        end
        S_MULT: begin
          ze <= $signed(op_a.exp) + $signed(op_b.exp) + E_ONE;
          zm <= prod4[PROD_W-1 -: MANT_W];
          g  <= prod4[PROD_W-MANT_W-1];
          rb <= prod4[PROD_W-MANT_W-2];
          sb <= |prod4[PROD_W-MANT_W-3:0];
          st <= S_NORM1;
        end
        S_NORM1: begin
          if (zm[MANT_W-1]) st <= S_NORM2;
          else begin
            zm <= {zm[MANT_W-2:0], g};
            g  <= rb;
            rb <= 1'b0;
            ze <= ze - E_ONE;
          end
        end
        S_NORM2: begin
          if (ze < E_MIN) begin
            ze <= ze + E_ONE;
            zm <= zm >> 1;
            g  <= zm[0];
            rb <= g;
            sb <= sb | rb;
          end else st <= S_ROUND;
        end
        S_ROUND: begin
          z_data  <= packed_w;
          z_valid <= 1'b1;
          st      <= S_PUT_Z;
        end
        S_PUT_Z: if (z_ack) begin
          z_valid <= 1'b0;
          a_ack   <= 1'b1;
          st      <= S_GET_A;
        end
        default: st <= S_GET_A;
      endcase
    end
  end
endmodule

// File: rtl/fmul_chk.sv
module fmul_chk
  import fmul_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] a_data,
  input logic              a_valid,
  input logic              a_ack,
  input logic [WORD_W-1:0] b_data,
  input logic              b_valid,
  input logic              b_ack,
  input logic [WORD_W-1:0] z_data,
  input logic              z_valid,
  input logic              z_ack
);
  logic [WORD_W-1:0] a_cap, b_cap;
  logic              cap_nan;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap <= '0;
      b_cap <= '0;
    end else begin
      if (a_valid && a_ack) a_cap <= a_data;
      if (b_valid && b_ack) b_cap <= b_data;
    end
  end

  assign cap_nan = ((&a_cap[WORD_W-2 -: EXP_W]) && (|a_cap[FRAC_W-1:0])) ||
                   ((&b_cap[WORD_W-2 -: EXP_W]) && (|b_cap[FRAC_W-1:0]));

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (a_ack && !b_ack && !z_valid));

  p_b_after_a_r1: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ack) |=> (b_ack && !a_ack));

  p_hold_z_r2: assert property (@(posedge clk) disable iff (rst)
    (z_valid && !z_ack) |=> (z_valid && $stable(z_data)));

  p_nan_out_r7: assert property (@(posedge clk) disable iff (rst)
    (z_valid && cap_nan) |-> (z_data == QNAN));

  p_sign_xor_r8: assert property (@(posedge clk) disable iff (rst)
    (z_valid && z_data != QNAN) |-> (z_data[WORD_W-1] == (a_cap[WORD_W-1] ^ b_cap[WORD_W-1])));

  p_acks_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(a_ack && b_ack) && !(z_valid && (a_ack || b_ack)));
endmodule

bind fmul32_seq fmul_chk chk_i (
  .clk(clk), .rst(rst), .a_data(a_data), .a_valid(a_valid), .a_ack(a_ack),
  .b_data(b_data), .b_valid(b_valid), .b_ack(b_ack),
  .z_data(z_data), .z_valid(z_valid), .z_ack(z_ack)
);

// File: tb/fmul32_seq_tb_top.sv
`timescale 1ns / 1ps
module fmul32_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_data = '0, b_data = '0;
  logic        a_valid = 1'b0, b_valid = 1'b0, z_ack = 1'b0;
  logic        a_ack, b_ack, z_valid;
  logic [31:0] z_data;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fmul32_seq dut_i (
    .clk(clk), .rst(rst), .a_data(a_data), .a_valid(a_valid), .a_ack(a_ack),
    .b_data(b_data), .b_valid(b_valid), .b_ack(b_ack),
    .z_data(z_data), .z_valid(z_valid), .z_ack(z_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Integer reference: exact product, single rounding step
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e, sh, msb;
    longint unsigned ma, mb, p, q, rem, half;
    s = a[31] ^ b[31];
    if ((&a[30:23] && |a[22:0]) || (&b[30:23] && |b[22:0])) return 32'hFFC00000;
    if (&a[30:23]) return (b[30:0] == 0) ? 32'hFFC00000 : {s, 8'hFF, 23'd0};
    if (&b[30:23]) return (a[30:0] == 0) ? 32'hFFC00000 : {s, 8'hFF, 23'd0};
    if (a[30:0] == 0 || b[30:0] == 0) return {s, 31'd0};
    ma = (a[30:23] == 0) ? {41'd0, a[22:0]} : {40'd0, 1'b1, a[22:0]};
    mb = (b[30:23] == 0) ? {41'd0, b[22:0]} : {40'd0, 1'b1, b[22:0]};
    ea = (a[30:23] == 0) ? -126 : int'(a[30:23]) - 127;
    eb = (b[30:23] == 0) ? -126 : int'(b[30:23]) - 127;
    p = ma * mb;
    msb = 0;
    for (int i = 0; i < 48; i++) if (p[i]) msb = i;
    e = msb - 46 + ea + eb;
    if (e < -126) e = -126;
    sh = e - 23 - (ea + eb - 46);
    if (sh <= 0) q = p << (-sh);
    else if (sh >= 60) q = 0;
    else begin
      q = p >> sh;
      rem = p & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && q[0])) q++;
    end
    if (q == (64'd1 << 24)) begin q = 64'd1 << 23; e++; end
    if (e > 127) return {s, 8'hFF, 23'd0};
    return {s, q[23] ? 8'(e + 127) : 8'd0, q[22:0]};
  endfunction

  task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input int hold, output logic [31:0] z);
    int n;
    @(negedge clk); a_data = a; a_valid = 1'b1; n = 0;
    while (!a_ack && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk); a_valid = 1'b0; b_data = b; b_valid = 1'b1; n = 0;
    while (!b_ack && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk); b_valid = 1'b0; n = 0;
    while (!z_valid && n < 3000) begin @(negedge clk); n++; end
    chk(!a_ack && !b_ack, "R9 acks low with result", {30'd0, a_ack, b_ack}, 32'd0);
    z = z_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(z_valid && z_data == z, "R2 held result", z_data, z);
    end
    z_ack = 1'b1;
    @(negedge clk); z_ack = 1'b0;
    if (hold > 0) chk(!z_valid && a_ack, "R2 release", {30'd0, z_valid, a_ack}, 32'd1);
  endtask

  task automatic mul_check(input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp, input string tag);
    logic [31:0] z;
    run_mul(a, b, 0, z);
    chk(z == exp, tag, z, exp);
  endtask

  task automatic t_reset_r1;
    chk({a_ack, b_ack, z_valid} == 3'b100, "R1 reset state", {29'd0, a_ack, b_ack, z_valid}, 32'd4);
  endtask

  task automatic t_order_r1;
    @(negedge clk); b_data = 32'h40000000; b_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(a_ack && !b_ack, "R1 b ignored before a", {30'd0, a_ack, b_ack}, 32'd2);
    b_valid = 1'b0;
    mul_check(32'h3FC00000, 32'h40000000, 32'h40400000, "R1 normal after ordering");
  endtask

  task automatic t_hold_r2;
    logic [31:0] z;
    run_mul(32'hC0400000, 32'h40000000, 5, z);
    chk(z == 32'hC0C00000, "R2 product value", z, 32'hC0C00000);
  endtask

  task automatic t_round_r3;
    mul_check(32'h3F800001, 32'h40400000, 32'h40400002, "R3 tie up to even");
    mul_check(32'h3F800003, 32'h40400000, 32'h40400004, "R3 tie down to even");
    mul_check(32'h3F800001, 32'h3F800001, 32'h3F800002, "R3 below half");
    mul_check(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, "R3 largest finite kept");
  endtask

  task automatic t_sub_in_r4;
    mul_check(32'h00000001, 32'h4B000000, 32'h00800000, "R4 subnormal to normal");
    mul_check(32'h00400000, 32'h40800000, 32'h01000000, "R4 subnormal times four");
    mul_check(32'h005EC72E, 32'h001FDDEB, ref_mul(32'h005EC72E, 32'h001FDDEB), "R4 two subnormals");
  endtask

  task automatic t_sub_out_r5;
    mul_check(32'h00800000, 32'h3F000000, 32'h00400000, "R5 exact subnormal");
    mul_check(32'h00800001, 32'h3F000000, 32'h00400000, "R5 subnormal tie even");
    mul_check(32'h00FFFFFF, 32'h3F000000, 32'h00800000, "R5 rounds to min normal");
    mul_check(32'h00800000, 32'hBE800000, 32'h80200000, "R5 negative subnormal");
  endtask

  task automatic t_range_r6;
    mul_check(32'h7F000000, 32'h7F000000, 32'h7F800000, "R6 overflow");
    mul_check(32'hFF000000, 32'h40000000, 32'hFF800000, "R6 negative overflow");
    mul_check(32'h7F7FFFFF, 32'h3F800001, 32'h7F800000, "R6 overflow by rounding");
    mul_check(32'h00000001, 32'h00000001, 32'h00000000, "R6 underflow");
    mul_check(32'h80000001, 32'h00800000, 32'h80000000, "R6 negative underflow");
  endtask

  task automatic t_nan_r7;
    mul_check(32'h7F800000, 32'h00000000, 32'hFFC00000, "R7 inf times zero");
    mul_check(32'h80000000, 32'hFF800000, 32'hFFC00000, "R7 zero times inf");
    mul_check(32'h7FC00001, 32'h3F800000, 32'hFFC00000, "R7 nan a");
    mul_check(32'h3F800000, 32'hFF800001, 32'hFFC00000, "R7 nan b");
  endtask

  task automatic t_sign_r8;
    mul_check(32'hFF800000, 32'h40000000, 32'hFF800000, "R8 neg inf");
    mul_check(32'h7F800000, 32'hC0000000, 32'hFF800000, "R8 inf times negative");
    mul_check(32'h80000000, 32'h40A00000, 32'h80000000, "R8 negative zero");
    mul_check(32'h80000000, 32'h80000000, 32'h00000000, "R8 zero signs cancel");
    mul_check(32'h00000000, 32'h00000001, 32'h00000000, "R8 zero times subnormal");
  endtask

  task automatic t_sweep_r3;
    logic [31:0] x, a, b;
    x = 32'h1234ABCD;
    for (int i = 0; i < 24; i++) begin
      x = x * 32'd1664525 + 32'd1013904223; a = x;
      x = x * 32'd1664525 + 32'd1013904223; b = x;
      if (i % 3 == 1) a[30:27] = 4'd0;
      if (i % 3 == 2) b[30] = ~a[30];
      mul_check(a, b, ref_mul(a, b), "R3 sweep");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_order_r1();
    t_hold_r2();
    t_round_r3();
    t_sub_in_r4();
    t_sub_out_r5();
    t_range_r6();
    t_nan_r7();
    t_sign_r8();
    t_sweep_r3();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule